// File: doc/BRIEF.md
# Three-Channel Down-Counter Timer with Watchdog Reset

This block is a small memory-mapped timer unit with three down-counting channels. Each channel has a live count and a reload value. A shared control word gives every channel a run bit and a repeat bit. Channel 0 is meant to be a periodic tick source that raises an interrupt. Channel 1 is meant to be a free-running time base that software reads. Channel 2 is a watchdog. When it expires it raises its own interrupt cause, and it can also assert a system reset output.

Software reaches the block through a plain 32-bit register port. A write is one cycle with `bus_wr` high. Read data is a combinational function of `bus_addr`. Two interrupt causes are kept: one for the tick channel and one for the watchdog. Each cause is cleared by writing 0 to its bit. Each interrupt line is gated by a mask bit. The watchdog reset output is enabled by a separate reset-out enable bit. Once asserted, the reset output stays high for a fixed number of clocks.

Top module: `timer_wdog_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_tick`, `irq_wdog` and `wdog_rst` are low. The registers are: control at 0x00, count n at 0x10+8n, reload n at 0x14+8n, cause at 0x40, mask at 0x44 and reset-out enable at 0x48. Unmapped addresses read 0.
- R2: Control bit 2n is the run bit of channel n and bit 2n+1 is its repeat bit. A running channel with repeat set counts down once per clock. From zero it loads its reload value on the next clock, so its period is reload+1 clocks.
- R3: A running channel without the repeat bit stops at zero and holds there.
- R4: A free-running channel wraps from zero to its reload value of 0xFFFFFFFF.
- R5: A write to a count register takes effect at the next clock edge. It overrides the decrement or reload of that cycle, whether or not the channel is running.
- R6: Cause bit 0 (tick, channel 0) and cause bit 1 (watchdog, channel 2) are set on the clock in which a running channel's count goes from 1 to 0. A cause write ANDs the written data into the cause bits: writing 0 clears a bit and writing 1 leaves it unchanged. A set in the same cycle wins over the clear.
- R7: `irq_tick` equals cause bit 0 AND mask bit 0, and `irq_wdog` equals cause bit 1 AND mask bit 1.
- R8: A watchdog expiry while reset-out enable (bit 0 at 0x48) is 0 leaves `wdog_rst` low.
- R9: A watchdog expiry while reset-out enable is 1 drives `wdog_rst` high for RST_HOLD (16) clocks, starting with the clock in which the count reaches 0. A new expiry restarts the hold count. The block's own reset clears the output.
- R10: A channel whose run bit is 0 keeps its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters step once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_tick | output | 1 | Tick interrupt (cause 0 and mask 0) |
| irq_wdog | output | 1 | Watchdog interrupt (cause 1 and mask 1) |
| wdog_rst | output | 1 | Watchdog reset output, held for RST_HOLD clocks |

## Verification
The tick channel runs in repeat mode with a short reload. This shows whether the period is reload+1 or reload clocks, and whether the cause bit is set on the 1-to-0 step. A one-shot run and a run with the run bit cleared separate stopping at zero from wrapping and from still counting. The time-base channel is started two counts from zero with a reload of 0xFFFFFFFF, which exposes the wrap value. A mid-run count write shows that the write takes priority over the decrement. The watchdog expires once with reset-out disabled and then repeatedly with it enabled and a reload shorter than the hold time. This checks the gating, the exact 16-clock pulse width and the restart of the hold count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int N_CH     = 3;
    localparam int ADDR_W   = 8;
    localparam int BUS_W    = 32;
    localparam int N_CAUSE  = 2;
    localparam int TICK_CH  = 0;
    localparam int WD_CH    = 2;
    localparam int CAUSE_TICK = 0;
    localparam int CAUSE_WD   = 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_CNT0   = 8'h10;
    localparam logic [ADDR_W-1:0] A_RLD0   = 8'h14;
    localparam int                A_STRIDE = 8;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 8'h40;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h44;
    localparam logic [ADDR_W-1:0] A_RMASK  = 8'h48;

    typedef struct packed {
        logic repeat_en;
        logic run;
    } ch_ctrl_t;

    function automatic logic [ADDR_W-1:0] cnt_addr(input int ch);
        return A_CNT0 + ADDR_W'(ch * A_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] rld_addr(input int ch);
        return A_RLD0 + ADDR_W'(ch * A_STRIDE);
    endfunction
endpackage

// File: rtl/timer_chan.sv
module timer_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         repeat_en,
    input  logic         cnt_we,
    input  logic         rld_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         expire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_we) begin
            count <= wdata;
        end else if (run) begin
            if (count == '0) begin
                if (repeat_en) count <= reload;
            end else begin
                count <= count - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reload <= '0;
        else if (rld_we) reload <= wdata;
    end

    assign expire = run && !cnt_we && (count == W'(1));

    // R5
    cnt_write_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> count == $past(wdata));
    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_we && count != '0) |=> count == $past(count) - W'(1));
    // R2
    cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run && repeat_en && !cnt_we && count == '0) |=> count == $past(reload));
    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(count));
endmodule

// File: rtl/tmr_rst_stretch.sv
module tmr_rst_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse_o
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (trig)          left_q <= CW'(HOLD);
        else if (left_q != '0)  left_q <= left_q - CW'(1);
    end

    assign pulse_o = (left_q != '0);

    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse_o);
endmodule

// File: rtl/timer_wdog_unit.sv
module timer_wdog_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int RST_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_tick,
    output logic              irq_wdog,
    output logic              wdog_rst
);
    localparam int CTRL_W = 2 * N_CH;

    ch_ctrl_t [N_CH-1:0]  ctrl_q;
    logic [N_CAUSE-1:0]   cause_q, mask_q, cause_set;
    logic                 rmask_q;
    logic [CNT_W-1:0]     cnt   [N_CH];
    logic [CNT_W-1:0]     rld   [N_CH];
    logic [N_CH-1:0]      cnt_we, rld_we, expire;
    logic                 wr_ctrl, wr_cause, wr_mask, wr_rmask;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_cause = bus_wr && (bus_addr == A_CAUSE);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);
    assign wr_rmask = bus_wr && (bus_addr == A_RMASK);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign cnt_we[g] = bus_wr && (bus_addr == cnt_addr(g));
        assign rld_we[g] = bus_wr && (bus_addr == rld_addr(g));
        timer_chan #(.W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .run      (ctrl_q[g].run),
            .repeat_en(ctrl_q[g].repeat_en),
            .cnt_we   (cnt_we[g]),
            .rld_we   (rld_we[g]),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .count    (cnt[g]),
            .reload   (rld[g]),
            .expire   (expire[g])
        );
    end

    always_comb begin
        cause_set = '0;
        cause_set[CAUSE_TICK] = expire[TICK_CH];
        cause_set[CAUSE_WD]   = expire[WD_CH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cause_q <= '0;
            mask_q  <= '0;
            rmask_q <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
            if (wr_mask)  mask_q  <= bus_wdata[N_CAUSE-1:0];
            if (wr_rmask) rmask_q <= bus_wdata[0];
            cause_q <= (wr_cause ? (cause_q & bus_wdata[N_CAUSE-1:0]) : cause_q)
                       | cause_set;
        end
    end

    assign irq_tick = cause_q[CAUSE_TICK] & mask_q[CAUSE_TICK];
    assign irq_wdog = cause_q[CAUSE_WD]   & mask_q[CAUSE_WD];

    tmr_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
        .clk    (clk),
        .rst    (rst),
        .trig   (expire[WD_CH] && rmask_q),
        .pulse_o(wdog_rst)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = BUS_W'(ctrl_q);
            A_CAUSE: bus_rdata = BUS_W'(cause_q);
            A_MASK:  bus_rdata = BUS_W'(mask_q);
            A_RMASK: bus_rdata = BUS_W'(rmask_q);
            default: begin
                for (int c = 0; c < N_CH; c++) begin
                    if (bus_addr == cnt_addr(c)) bus_rdata = BUS_W'(cnt[c]);
                    if (bus_addr == rld_addr(c)) bus_rdata = BUS_W'(rld[c]);
                end
            end
        endcase
    end

    // R6
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_cause && cause_set == '0) |=> $stable(cause_q));
    // R8
    rst_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_rst) |-> $past(rmask_q));
endmodule

// File: tb/timer_wdog_unit_tb_top.sv
module timer_wdog_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_tick, irq_wdog, wdog_rst;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    timer_wdog_unit dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_wdog(irq_wdog), .wdog_rst(wdog_rst)
    );

    // behavioural reference model
    logic [31:0] m_cnt [3];
    logic [31:0] m_rl  [3];
    logic [5:0]  m_ctrl;
    logic [1:0]  m_cause, m_mask;
    logic        m_rmask;
    int          m_hold;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {26'd0, m_ctrl};
            8'h10: return m_cnt[0];
            8'h18: return m_cnt[1];
            8'h20: return m_cnt[2];
            8'h14: return m_rl[0];
            8'h1C: return m_rl[1];
            8'h24: return m_rl[2];
            8'h40: return {30'd0, m_cause};
            8'h44: return {30'd0, m_mask};
            8'h48: return {31'd0, m_rmask};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_rl[i] = 0; end
            m_ctrl = 0; m_cause = 0; m_mask = 0; m_rmask = 0; m_hold = 0;
        end else begin
            bit [2:0] ex;
            logic [31:0] old_rl [3];
            logic old_rmask;
            old_rmask = m_rmask;
            for (int i = 0; i < 3; i++) old_rl[i] = m_rl[i];
            for (int i = 0; i < 3; i++) begin
                bit wc, en, au;
                wc = bus_wr && (bus_addr == 8'(16 + 8 * i));
                en = m_ctrl[2 * i];
                au = m_ctrl[2 * i + 1];
                ex[i] = !wc && en && (m_cnt[i] == 1);
                if (wc) m_cnt[i] = bus_wdata;
                else if (en) begin
                    if (m_cnt[i] == 0) begin
                        if (au) m_cnt[i] = old_rl[i];
                    end else m_cnt[i] = m_cnt[i] - 1;
                end
                if (bus_wr && (bus_addr == 8'(20 + 8 * i))) m_rl[i] = bus_wdata;
            end
            if (bus_wr && bus_addr == 8'h40) m_cause = m_cause & bus_wdata[1:0];
            m_cause = m_cause | {ex[2], ex[0]};
            if (bus_wr && bus_addr == 8'h00) m_ctrl = bus_wdata[5:0];
            if (bus_wr && bus_addr == 8'h44) m_mask = bus_wdata[1:0];
            if (bus_wr && bus_addr == 8'h48) m_rmask = bus_wdata[0];
            if (ex[2] && old_rmask) m_hold = 16;
            else if (m_hold > 0) m_hold--;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("irq_tick", {31'd0, irq_tick}, {31'd0, m_cause[0] & m_mask[0]});
            chk("irq_wdog", {31'd0, irq_wdog}, {31'd0, m_cause[1] & m_mask[1]});
            chk("wdog_rst", {31'd0, wdog_rst}, {31'd0, m_hold != 0});
            chk("bus_rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_idle(input logic [7:0] a, input int n);
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state of all registers
        cur_req = "R1";
        foreach (m_rl[k]) begin end
        begin
            logic [7:0] addrs [10] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C,
                                      8'h20, 8'h24, 8'h40, 8'h44, 8'h48};
            foreach (addrs[j]) rd_idle(addrs[j], 1);
            rd_idle(8'h3C, 1);
        end
        // R2 periodic tick channel, R7 mask gating
        cur_req = "R2";
        wr(8'h14, 32'd4);
        wr(8'h10, 32'd4);
        wr(8'h00, 32'h3);
        rd_idle(8'h10, 14);
        cur_req = "R7";
        wr(8'h44, 32'h1);
        rd_idle(8'h40, 8);
        // R6 write 1 keeps, write 0 clears
        cur_req = "R6";
        wr(8'h00, 32'h0);
        wr(8'h40, 32'h3);
        rd_idle(8'h40, 2);
        wr(8'h40, 32'h0);
        rd_idle(8'h40, 2);
        // R3 one-shot stops at zero
        cur_req = "R3";
        wr(8'h18, 32'd3);
        wr(8'h00, 32'h4);
        rd_idle(8'h18, 8);
        // R10 stopped channel holds
        cur_req = "R10";
        wr(8'h00, 32'h0);
        wr(8'h18, 32'd5);
        rd_idle(8'h18, 6);
        // R4 free-running wrap to all ones
        cur_req = "R4";
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h18, 32'd2);
        wr(8'h00, 32'hC);
        rd_idle(8'h18, 6);
        // R5 count write overrides decrement
        cur_req = "R5";
        wr(8'h18, 32'd100);
        rd_idle(8'h18, 3);
        wr(8'h00, 32'h0);
        // R8 watchdog expiry with reset-out disabled
        cur_req = "R8";
        wr(8'h44, 32'h2);
        wr(8'h20, 32'd3);
        wr(8'h00, 32'h10);
        rd_idle(8'h40, 8);
        // R9 reset pulse, restart, and clear by reset
        cur_req = "R9";
        wr(8'h48, 32'h1);
        wr(8'h24, 32'd10);
        wr(8'h20, 32'd2);
        wr(8'h00, 32'h30);
        rd_idle(8'h20, 40);
        wr(8'h00, 32'h0);
        rd_idle(8'h20, 20);
        wr(8'h20, 32'd2);
        wr(8'h00, 32'h10);
        rd_idle(8'h20, 4);
        @(negedge clk); #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        rd_idle(8'h48, 3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule